// File: doc/BRIEF.md
# Dual-State Bank-Switching Memory Mapper

This block sits beside an 8-bit main processor and turns each memory request into one chip select plus three remapped high address bits. The map in use is chosen by a 2-bit system state held in an I/O register: an initialise map used straight after power-on, a disk-operating-system map that is almost all DRAM, and two interpreter maps, one running from a 32 KB mask ROM and one running from RAM. Two bank fields refine the map. A 4-bit field remaps the top 16 KB window. A 3-bit field remaps the 8 KB window at 2000h, and it does so only in the interpreter states. The top 2 KB is always the RAM shared with the sub-processor.

Software programs the mapper through four I/O ports, FCh to FFh. The same registers drive the sub-processor hold line and bus request. Two overlay enables hand the 4000h–7FFFh and 8000h–BFFFh regions to external memory and suppress DRAM bank A there. A refresh cycle strobes every DRAM bank and selects nothing else. Every opcode fetch is stretched by exactly one wait cycle.

Top module: `bank_mapper`

## Requirements
- R1: After reset the ports FCh, FDh and FEh read back 00h, `sub_hold` is 1, `sub_busreq` is 0, `wait_o` is 0 and the map is the initialise state.
- R2: An I/O write whose address bits 7:2 are all ones updates the register picked by bits 1:0. FCh bit 1 is the sub-processor bus request. FDh holds bit 7 as run, where 1 clears `sub_hold`, bits 5:4 as the state and bits 3:0 as the top-window bank. FEh holds bits 4:3 as the overlay enables (bit 3 for 4000h, bit 4 for 8000h) and bits 2:0 as the low-window bank. An I/O read returns the same layout. A write to FFh changes nothing, and FFh reads 00h.
- R3: State 0 (initialise): page 0000h–1FFFh selects the IPL ROM with ra 0, page 2000h–3FFFh selects the 32 KB ROM with ra 0 for the presence test, and every other page below F800h selects nothing.
- R4: State 1 (disk system) maps pages 0–5 to DRAM bank A with ra equal to the page number. State 3 maps the same way every page outside the two windows.
- R5: In states 1–3, pages C000h–FFFFh below F800h select the DRAM bank given by bank field bits 1:0 (0 = A … 3 = D), with ra = {bits 3:2, A13}.
- R6: In states 2 and 3, page 2000h–3FFFh is decoded from the 3-bit field with ra 1. Value 0 selects the 32 KB ROM in state 2 and DRAM bank A in state 3. Values 1–4 select option slots 0–3. Values 5–7 select DRAM bank A.
- R7: The 32 KB ROM and the slot selects assert only in states 2 and 3 (apart from the presence test of R3). State 2 maps pages 0, 2 and 3 to the 32 KB ROM with ra equal to the page number, and pages 4–5 to DRAM bank A.
- R8: Addresses F800h–FFFFh select the common RAM in every state, with no DRAM strobe.
- R9: In states 2 and 3, when an overlay enable is set and its region would go to DRAM bank A, the overlay select asserts instead (`cs_ovl[0]` for 4000h–7FFFh, `cs_ovl[1]` for 8000h–BFFFh) and bank A is not strobed. In state 1 the overlays have no effect.
- R10: During refresh every DRAM strobe asserts and no ROM, slot, overlay or common-RAM select asserts.
- R11: Each opcode fetch raises `wait_o` for exactly one clock, starting at the first edge of the fetch.
- R12: With `mreq_n` high, no select or strobe asserts and `ra_hi` equals A15–A13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| din | input | 8 | Data bus for I/O writes |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh cycle, active low |
| m1_n | input | 1 | Opcode fetch cycle, active low |
| dout | output | 8 | Register read data, 00h outside a port read |
| ra_hi | output | 3 | Remapped address bits 15:13 |
| cs_ipl | output | 1 | IPL ROM select |
| cs_rom32 | output | 1 | 32 KB interpreter ROM select |
| cs_slot | output | 4 | Option ROM slot selects |
| ras | output | 4 | DRAM bank strobes A–D |
| cs_com | output | 1 | Shared common RAM select |
| cs_ovl | output | 2 | Overlay memory selects |
| wait_o | output | 1 | Wait request to the processor |
| sub_hold | output | 1 | Sub-processor held in reset |
| sub_busreq | output | 1 | Bus request to the sub-processor |

## Verification
A corrupted state or bank register shows up at once in the next memory cycle: the processor addresses the wrong device, or two devices, or none. The bench therefore compares every select and `ra_hi` against a table model in each state, across all bank and overlay values, on the same cycle the request is driven. A stuck wait flag shows within one clock as a wait that lasts two cycles or a fetch that gets no wait. A lost write shows on the next port readback.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned NUM_OVL   = 2;

  localparam logic [1:0] ST_INIT = 2'd0;
  localparam logic [1:0] ST_SYS  = 2'd1;
  localparam logic [1:0] ST_ROMB = 2'd2;
  localparam logic [1:0] ST_RAMB = 2'd3;

  typedef enum logic [2:0] {
    T_NONE, T_IPL, T_ROM32, T_SLOT, T_RAM, T_COM, T_OVL
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [1:0] idx;
    logic [2:0] ra;
  } map_t;

  typedef struct packed {
    logic       run;
    logic       busreq;
    logic [1:0] state;
    logic [3:0] hib;
    logic [2:0] lob;
    logic [1:0] ovl;
  } ctl_t;
endpackage

// File: rtl/bmm_regs.sv
module bmm_regs
  import bmm_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [5:0]  IO_BASE = 6'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output ctl_t          ctl,
  output logic [DW-1:0] dout
);
  localparam int unsigned SELW = 2;

  logic            hit;
  logic [SELW-1:0] sel;
  logic            wr_en;
  ctl_t            ctl_d;
  ctl_t            ctl_q;

  assign hit   = ~iorq_n && (addr[7:2] == IO_BASE);
  assign sel   = addr[SELW-1:0];
  assign wr_en = hit && ~wr_n;

  always_comb begin
    ctl_d = ctl_q;
    unique case (sel)
      2'd0: ctl_d.busreq = din[1];
      2'd1: begin
        ctl_d.run   = din[7];
        ctl_d.state = din[5:4];
        ctl_d.hib   = din[3:0];
      end
      2'd2: begin
        ctl_d.ovl = din[4:3];
        ctl_d.lob = din[2:0];
      end
      default: ctl_d = ctl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    dout = '0;
    if (hit && ~rd_n) begin
      unique case (sel)
        2'd0: dout = {6'b0, ctl_q.busreq, 1'b0};
        2'd1: dout = {ctl_q.run, 1'b0, ctl_q.state, ctl_q.hib};
        2'd2: dout = {3'b0, ctl_q.ovl, ctl_q.lob};
        default: dout = '0;
      endcase
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/bmm_decode.sv
module bmm_decode
  import bmm_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [4:0]  COM_TOP = 5'h1F
) (
  input  logic [AW-1:0] addr,
  input  ctl_t          ctl,
  output map_t          m
);
  localparam int unsigned PW = 3;

  logic [PW-1:0] page;
  logic          com;

  assign page = addr[AW-1 -: PW];
  assign com  = addr[AW-1 -: 5] == COM_TOP;

  always_comb begin
    m = '{tgt: T_NONE, idx: 2'd0, ra: page};
    if (com) begin
      m.tgt = T_COM;
    end else if (ctl.state == ST_INIT) begin
      if (page == 3'd0) begin
        m.tgt = T_IPL;
        m.ra  = 3'd0;
      end else if (page == 3'd1) begin
        m.tgt = T_ROM32;
        m.ra  = 3'd0;
      end
    end else begin
      if (page >= 3'd6) begin
        m.tgt = T_RAM;
        m.idx = ctl.hib[1:0];
        m.ra  = {ctl.hib[3:2], addr[AW-3]};
      end else if (page == 3'd1 && ctl.state != ST_SYS) begin
        if (ctl.lob == 3'd0 && ctl.state == ST_ROMB) begin
          m.tgt = T_ROM32;
        end else if (ctl.lob != 3'd0 && ctl.lob <= 3'(NUM_SLOTS)) begin
          m.tgt = T_SLOT;
          m.idx = 2'(ctl.lob - 3'd1);
        end else begin
          m.tgt = T_RAM;
        end
      end else if (ctl.state == ST_ROMB && page <= 3'd3) begin
        m.tgt = T_ROM32;
      end else begin
        m.tgt = T_RAM;
      end
      if (m.tgt == T_RAM && m.idx == 2'd0 && ctl.state != ST_SYS) begin
        if (ctl.ovl[0] && page[2:1] == 2'b01) begin
          m.tgt = T_OVL;
          m.idx = 2'd0;
        end else if (ctl.ovl[1] && page[2:1] == 2'b10) begin
          m.tgt = T_OVL;
          m.idx = 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/bmm_wait.sv
module bmm_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch,
  output logic wait_o
);
  logic wait_q, wait_d;
  logic done_q, done_d;

  always_comb begin
    wait_d = 1'b0;
    done_d = done_q;
    if (!fetch) begin
      done_d = 1'b0;
    end else if (!done_q) begin
      wait_d = 1'b1;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
      done_q <= done_d;
    end
  end

  assign wait_o = wait_q;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bmm_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        din,
  input  logic                 mreq_n,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 rfsh_n,
  input  logic                 m1_n,
  output logic [DW-1:0]        dout,
  output logic [2:0]           ra_hi,
  output logic                 cs_ipl,
  output logic                 cs_rom32,
  output logic [NUM_SLOTS-1:0] cs_slot,
  output logic [NUM_BANKS-1:0] ras,
  output logic                 cs_com,
  output logic [NUM_OVL-1:0]   cs_ovl,
  output logic                 wait_o,
  output logic                 sub_hold,
  output logic                 sub_busreq
);
  ctl_t ctl;
  map_t m;
  logic norm;
  logic refresh;

  bmm_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .ctl(ctl), .dout(dout)
  );

  bmm_decode #(.AW(AW)) u_dec (.addr(addr), .ctl(ctl), .m(m));

  bmm_wait u_wait (
    .clk(clk), .rst_n(rst_n),
    .fetch(~m1_n && ~mreq_n && rfsh_n), .wait_o(wait_o)
  );

  assign norm     = ~mreq_n && rfsh_n;
  assign refresh  = ~mreq_n && ~rfsh_n;
  assign ra_hi    = norm ? m.ra : addr[AW-1 -: 3];
  assign cs_ipl   = norm && m.tgt == T_IPL;
  assign cs_rom32 = norm && m.tgt == T_ROM32;
  assign cs_com   = norm && m.tgt == T_COM;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign cs_slot[s] = norm && m.tgt == T_SLOT && m.idx == 2'(s);
  end
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ras
    assign ras[b] = refresh || (norm && m.tgt == T_RAM && m.idx == 2'(b));
  end
  for (genvar o = 0; o < NUM_OVL; o++) begin : g_ovl
    assign cs_ovl[o] = norm && m.tgt == T_OVL && m.idx == 2'(o);
  end

  assign sub_hold   = ~ctl.run;
  assign sub_busreq = ctl.busreq;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        mreq_n,
  input logic        rfsh_n,
  input logic        m1_n,
  input logic        cs_ipl,
  input logic        cs_rom32,
  input logic [3:0]  cs_slot,
  input logic [3:0]  ras,
  input logic        cs_com,
  input logic [1:0]  cs_ovl,
  input logic        wait_o
);
  logic [9:0] sels;
  assign sels = {cs_ipl, cs_rom32, cs_slot, cs_com, cs_ovl, |ras};

  p_refresh_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> !(cs_ipl || cs_rom32 || |cs_slot || cs_com || |cs_ovl));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (sels == 10'd0));
  p_single_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && rfsh_n) |-> ($countones(sels) <= 1 && $onehot0(ras)));
  p_common_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && rfsh_n && addr[15:11] == 5'h1F) |-> (cs_com && ras == 4'd0));
  p_overlay_no_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_ovl) |-> !ras[0]);
  p_wait_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |=> !wait_o);
  p_wait_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_o) |-> $past(!m1_n && !mreq_n && rfsh_n));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
  .m1_n(m1_n), .cs_ipl(cs_ipl), .cs_rom32(cs_rom32), .cs_slot(cs_slot),
  .ras(ras), .cs_com(cs_com), .cs_ovl(cs_ovl), .wait_o(wait_o)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        rfsh_n = 1'b1, m1_n = 1'b1;
  logic [7:0]  dout;
  logic [2:0]  ra_hi;
  logic        cs_ipl, cs_rom32, cs_com, wait_o, sub_hold, sub_busreq;
  logic [3:0]  cs_slot, ras;
  logic [1:0]  cs_ovl;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .m1_n(m1_n),
    .dout(dout), .ra_hi(ra_hi), .cs_ipl(cs_ipl), .cs_rom32(cs_rom32),
    .cs_slot(cs_slot), .ras(ras), .cs_com(cs_com), .cs_ovl(cs_ovl),
    .wait_o(wait_o), .sub_hold(sub_hold), .sub_busreq(sub_busreq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] outv();
    return {cs_ipl, cs_rom32, cs_slot, ras, cs_com, cs_ovl, ra_hi};
  endfunction

  // Reference table: {ipl, rom32, slot[3:0], ras[3:0], com, ovl[1:0], ra[2:0]}
  function automatic logic [15:0] model(int st, int hb, int lb, int ov, logic [15:0] a);
    int p = int'(a[15:13]);
    logic [15:0] v = '0;
    int bank = -1;
    v[2:0] = 3'(p);
    if (a[15:11] == 5'h1F) begin v[5] = 1'b1; return v; end
    if (st == 0) begin
      if (p == 0) v[15] = 1'b1;
      if (p == 1) v[14] = 1'b1;
      if (p <= 1) v[2:0] = 3'd0;
      return v;
    end
    if (p >= 6) begin
      v[6 + (hb % 4)] = 1'b1;
      v[2:0] = {2'(hb / 4), a[13]};
      return v;
    end
    if (p == 1 && st != 1) begin
      if (lb >= 1 && lb <= 4) v[9 + lb] = 1'b1;
      else if (lb == 0 && st == 2) v[14] = 1'b1;
      else bank = 0;
    end else if (st == 2 && p != 1 && p <= 3) v[14] = 1'b1;
    else bank = 0;
    if (bank == 0) begin
      if (st != 1 && (p == 2 || p == 3) && ov[0]) v[3] = 1'b1;
      else if (st != 1 && (p == 4 || p == 5) && ov[1]) v[4] = 1'b1;
      else v[6] = 1'b1;
    end
    return v;
  endfunction

  function automatic string tag_of(int st, logic [15:0] a);
    int p = int'(a[15:13]);
    if (a[15:11] == 5'h1F) return "R8";
    if (st == 0) return "R3";
    if (p >= 6) return "R5";
    if (p == 1 && st != 1) return "R6";
    if (st == 2 && p <= 3) return "R7";
    if (st != 1 && p >= 2 && p <= 5) return "R9";
    return "R4";
  endfunction

  task automatic io_wr(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    addr = {8'h00, port}; din = d; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic io_rd(input logic [7:0] port, output logic [7:0] d);
    @(negedge clk);
    addr = {8'h00, port}; iorq_n = 1'b0; rd_n = 1'b0;
    #1 d = dout;
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic mem_look(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = 1'b0;
    #1 v = outv();
    mreq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic [15:0] v;
    check("R1 sub_hold", 32'(sub_hold), 32'd1);
    check("R1 sub_busreq", 32'(sub_busreq), 32'd0);
    check("R1 wait", 32'(wait_o), 32'd0);
    io_rd(8'hFC, d); check("R1 FC", 32'(d), 32'h00);
    io_rd(8'hFD, d); check("R1 FD", 32'(d), 32'h00);
    io_rd(8'hFE, d); check("R1 FE", 32'(d), 32'h00);
    mem_look(16'h0010, v); check("R1 initial map", 32'(v), 32'(model(0, 0, 0, 0, 16'h0010)));
  endtask

  task automatic t_regs();
    logic [7:0] d;
    io_wr(8'hFC, 8'hFF);
    io_rd(8'hFC, d); check("R2 FC readback", 32'(d), 32'h02);
    check("R2 busreq pin", 32'(sub_busreq), 32'd1);
    io_wr(8'hFD, 8'hDA);
    io_rd(8'hFD, d); check("R2 FD readback", 32'(d), 32'h9A);
    check("R2 hold released", 32'(sub_hold), 32'd0);
    io_wr(8'hFE, 8'hFF);
    io_rd(8'hFE, d); check("R2 FE readback", 32'(d), 32'h1F);
    io_wr(8'hFF, 8'h00);
    io_rd(8'hFD, d); check("R2 FF write ignored FD", 32'(d), 32'h9A);
    io_rd(8'hFE, d); check("R2 FF write ignored FE", 32'(d), 32'h1F);
    io_rd(8'hFF, d); check("R2 FF reads zero", 32'(d), 32'h00);
    io_wr(8'hFC, 8'h00);
    io_wr(8'hFD, 8'h00);
    io_wr(8'hFE, 8'h00);
    check("R2 hold reasserted", 32'(sub_hold), 32'd1);
  endtask

  task automatic t_sweep();
    logic [15:0] v;
    logic [15:0] a;
    for (int st = 0; st < 4; st++)
      for (int hb = 0; hb < 16; hb++)
        for (int lb = 0; lb < 8; lb++)
          for (int ov = 0; ov < 4; ov++) begin
            io_wr(8'hFD, 8'(st * 16 + hb));
            io_wr(8'hFE, 8'(ov * 8 + lb));
            for (int k = 0; k < 10; k++) begin
              a = (k < 8) ? 16'(k * 16'h2000 + 16'h0123) : (k == 8 ? 16'hF800 : 16'hF7FF);
              mem_look(a, v);
              check(tag_of(st, a), 32'(v), 32'(model(st, hb, lb, ov, a)));
            end
          end
  endtask

  task automatic t_refresh();
    io_wr(8'hFD, 8'h20);
    io_wr(8'hFE, 8'h19);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addr = 16'(k * 16'h2000 + 16'h0700); mreq_n = 1'b0; rfsh_n = 1'b0;
      #1;
      check("R10 refresh selects", 32'(outv() >> 3), 32'({2'b00, 4'h0, 4'hF, 1'b0, 2'b00}));
      mreq_n = 1'b1; rfsh_n = 1'b1;
    end
  endtask

  task automatic t_idle();
    io_wr(8'hFD, 8'h35);
    @(negedge clk);
    addr = 16'hA5A5; mreq_n = 1'b1;
    #1;
    check("R12 idle selects", 32'(outv() >> 3), 32'd0);
    check("R12 idle ra_hi", 32'(ra_hi), 32'd5);
    addr = 16'hFA00;
    #1;
    check("R12 idle common", 32'(cs_com), 32'd0);
  endtask

  task automatic t_wait();
    for (int n = 0; n < 2; n++) begin
      @(negedge clk);
      addr = 16'h1000; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
      #1 check("R11 no wait before edge", 32'(wait_o), 32'd0);
      @(negedge clk); check("R11 wait in first cycle", 32'(wait_o), 32'd1);
      @(negedge clk); check("R11 wait one cycle only", 32'(wait_o), 32'd0);
      @(negedge clk); check("R11 wait stays low", 32'(wait_o), 32'd0);
      m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
      @(negedge clk); check("R11 no wait idle", 32'(wait_o), 32'd0);
    end
    @(negedge clk);
    mreq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); check("R11 data read no wait", 32'(wait_o), 32'd0);
    mreq_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sweep();
    t_refresh();
    t_idle();
    t_wait();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule